// File: doc/BRIEF.md
# Protected Two-Level Pin Function Configuration Bank

This block holds the function, bias and drive settings for a row of I/O pins and presents them, per pin, to the pad ring. Software programs it over a simple register bus. There are two register pages. Each page holds one word per pin.

The first page sets the primary function code, the pull bias and the drive code. The all-ones primary code hands the pin over to the second page, which carries a wider secondary function code. The second page also holds two 3-bit selectors. Each selector picks the source for one management-data channel: high impedance or one of seven internal controllers.

Each page has its own key-style lock register. A page is unlocked or relocked only by writing to the lock register a value whose upper 31 bits equal the lock register's own physical bus address. Bit 0 of that value gives the new lock state. While a page is locked, writes to its data words are dropped. For every pin the block drives a registered, unique function index: primary codes below 15 pass through unchanged, and secondary codes appear as 16 plus the secondary value.

Top module: `pinmux_cfg_bank`

## Requirements
- R1: After synchronous reset, both pages are locked and every stored field and selector reads 0. Every pin output and selector output is 0.
- R2: Bus offsets, with a byte address and `bus_addr[11]` selecting the page:
  - Page 0 lock register: offset 0x400. Page 1 lock register: offset 0xC00.
  - The physical address of a lock register is `PHYS_BASE` plus its offset.
  - A write to a lock register changes the lock only when write data bits 31:1 equal bits 31:1 of that physical address; the lock then becomes data bit 0 (1 locked, 0 unlocked).
  - A write whose key bits do not match changes nothing.
- R3: A read of a lock register returns its physical address with the current lock state in bit 0.
- R4: While a page is locked, writes to its pin words (and, for page 1, to its selectors) leave the stored values unchanged. Reads still return the stored values.
- R5: Pin n's page-0 word sits at offset 4*n. Its fields are:
  - function in bits 3:0
  - pull code in bits 9:8 (00 none, 01 up, 11 down)
  - drive code in bits 11:10 (0..3 for 4, 6, 8, 12 mA)
  All other bits read 0.
- R6: Pin n's page-1 word sits at offset 0x800+4*n and keeps bits 5:0 only. The two selectors sit at offsets 0xC04 (channel 0) and 0xC08 (channel 1) and keep bits 2:0 only.
- R7: The pin's function index equals the primary code when that code is below 15. When the primary code is 15, the index is 16 plus the secondary code.
- R8: The per-pin outputs (function, pull, drive) update on the clock edge after the edge that stores a new value. The selector outputs follow their register directly.
- R9: The two lock states are independent: changing one never changes the other.
- R10: Pin word offsets at or beyond `NUM_PINS` ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | AW | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| pin_func | output | NUM_PINS*7 | Per-pin function index, pin n at bits 7n+6:7n |
| pin_pull | output | NUM_PINS*2 | Per-pin pull code |
| pin_drive | output | NUM_PINS*2 | Per-pin drive code |
| mdio_src | output | 6 | Selector for channel 0 in bits 2:0, channel 1 in bits 5:3 |

## Verification
The in-line assertions check the following on every cycle:
- A mismatched key never moves a lock, and a matched key installs the written lock bit.
- Writes aimed at a locked page never disturb its stored pin words or selectors.
- No pin ever reports the unused index 15.

Only the bench's scenarios show the rest, by running a behavioural model of the register file in lock-step. This covers the field positions within each word, the unique-index folding of escalated pins, the one-cycle output latency, the read-back format of the lock registers and the handling of offsets past the last pin.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int DATA_W    = 32;
  localparam int PRI_W     = 4;
  localparam int SEC_W     = 6;
  localparam int IDX_OUT_W = 7;
  localparam int BIAS_W    = 2;
  localparam int DRV_W     = 2;
  localparam int SRC_W     = 3;
  localparam int SRC_CH    = 2;
  localparam logic [PRI_W-1:0] PRI_ESCALATE = '1;
  localparam int SEC_OFFSET = 16;

  // packed primary-page contents per pin
  typedef struct packed {
    logic [DRV_W-1:0]  drive;
    logic [BIAS_W-1:0] pull;
    logic [PRI_W-1:0]  func;
  } pri_word_t;

  localparam int PRI_PACK_W = $bits(pri_word_t);
endpackage

// File: rtl/pmx_lock.sv
module pmx_lock #(
  parameter logic [31:0] PHYS_ADDR = 32'h0000_0400
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic        locked
);
  localparam logic [30:0] KEY = PHYS_ADDR[31:1];
  logic key_ok;

  assign key_ok = (wdata[31:1] == KEY);

  always_ff @(posedge clk) begin
    if (rst)                 locked <= 1'b1;
    else if (wr_en && key_ok) locked <= wdata[0];
  end

  // R2: a wrong key never moves the lock
  assert_badkey_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !key_ok) |=> $stable(locked));
  // R2: a matching key installs the written lock bit
  assert_goodkey_take_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && key_ok) |=> (locked == $past(wdata[0])));
endmodule

// File: rtl/pmx_field_bank.sv
module pmx_field_bank #(
  parameter int NUM_PINS = 170,
  parameter int W        = 8,
  parameter int IDX_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [IDX_W-1:0]      idx,
  input  logic [W-1:0]          wdata,
  output logic [W-1:0]          rdata,
  output logic [NUM_PINS*W-1:0] flat
);
  logic [W-1:0] q [NUM_PINS];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)                          q[i] <= '0;
      else if (we && idx == IDX_W'(i))  q[i] <= wdata;
    end
    assign flat[i*W +: W] = q[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (idx == IDX_W'(i)) rdata = q[i];
  end
endmodule

// File: rtl/pmx_resolve.sv
module pmx_resolve
  import pmx_pkg::*;
#(
  parameter int NUM_PINS = 170
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PINS*PRI_PACK_W-1:0] pri_flat,
  input  logic [NUM_PINS*SEC_W-1:0]      sec_flat,
  output logic [NUM_PINS*IDX_OUT_W-1:0]  func_o,
  output logic [NUM_PINS*BIAS_W-1:0]     pull_o,
  output logic [NUM_PINS*DRV_W-1:0]      drive_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pri_word_t       pw;
    logic [SEC_W-1:0] sw;
    assign pw = pri_word_t'(pri_flat[i*PRI_PACK_W +: PRI_PACK_W]);
    assign sw = sec_flat[i*SEC_W +: SEC_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        func_o[i*IDX_OUT_W +: IDX_OUT_W] <= '0;
        pull_o[i*BIAS_W +: BIAS_W]       <= '0;
        drive_o[i*DRV_W +: DRV_W]        <= '0;
      end else begin
        func_o[i*IDX_OUT_W +: IDX_OUT_W] <= (pw.func == PRI_ESCALATE)
          ? IDX_OUT_W'(SEC_OFFSET) + IDX_OUT_W'(sw)
          : IDX_OUT_W'(pw.func);
        pull_o[i*BIAS_W +: BIAS_W]       <= pw.pull;
        drive_o[i*DRV_W +: DRV_W]        <= pw.drive;
      end
    end

    // R7: index 15 is reserved and never reported
    assert_no_idx15_R7: assert property (@(posedge clk) disable iff (rst)
      func_o[i*IDX_OUT_W +: IDX_OUT_W] != IDX_OUT_W'(15));
  end
endmodule

// File: rtl/pinmux_cfg_bank.sv
module pinmux_cfg_bank
  import pmx_pkg::*;
#(
  parameter int          NUM_PINS  = 170,
  parameter int          AW        = 12,
  parameter logic [31:0] PHYS_BASE = 32'h4000_0000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic [AW-1:0]                 bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic [NUM_PINS*IDX_OUT_W-1:0] pin_func,
  output logic [NUM_PINS*BIAS_W-1:0]    pin_pull,
  output logic [NUM_PINS*DRV_W-1:0]     pin_drive,
  output logic [SRC_CH*SRC_W-1:0]       mdio_src
);
  localparam int          IDX_W     = AW - 4;
  localparam logic [31:0] PAGE_SPAN = 32'(1) << (AW - 1);
  localparam logic [31:0] LOCK_OFS  = 32'(1) << (AW - 2);
  localparam logic [IDX_W:0] NP_LIM = (IDX_W+1)'(NUM_PINS);

  // address decode
  logic             page, ctl_area, pin_ok;
  logic [IDX_W-1:0] idx;
  logic             wr, rd;
  assign page     = bus_addr[AW-1];
  assign ctl_area = bus_addr[AW-2];
  assign idx      = bus_addr[AW-3:2];
  assign pin_ok   = !ctl_area && ({1'b0, idx} < NP_LIM);
  assign wr       = bus_en && bus_we;
  assign rd       = bus_en && !bus_we;

  // per-page lock registers
  logic [1:0] lock;
  for (genvar p = 0; p < 2; p++) begin : g_lock
    pmx_lock #(.PHYS_ADDR(PHYS_BASE + LOCK_OFS + PAGE_SPAN * p)) u_lock (
      .clk(clk), .rst(rst),
      .wr_en(wr && page == 1'(p) && ctl_area && idx == '0),
      .wdata(bus_wdata), .locked(lock[p]));
  end

  // per-pin storage
  pri_word_t                      pri_wr;
  logic [PRI_PACK_W-1:0]          pri_rd;
  logic [SEC_W-1:0]               sec_rd;
  logic [NUM_PINS*PRI_PACK_W-1:0] pri_flat;
  logic [NUM_PINS*SEC_W-1:0]      sec_flat;
  assign pri_wr = '{drive: bus_wdata[11:10], pull: bus_wdata[9:8], func: bus_wdata[3:0]};

  pmx_field_bank #(.NUM_PINS(NUM_PINS), .W(PRI_PACK_W), .IDX_W(IDX_W)) u_pri (
    .clk(clk), .rst(rst), .we(wr && !page && pin_ok && !lock[0]),
    .idx(idx), .wdata(pri_wr), .rdata(pri_rd), .flat(pri_flat));

  pmx_field_bank #(.NUM_PINS(NUM_PINS), .W(SEC_W), .IDX_W(IDX_W)) u_sec (
    .clk(clk), .rst(rst), .we(wr && page && pin_ok && !lock[1]),
    .idx(idx), .wdata(bus_wdata[SEC_W-1:0]), .rdata(sec_rd), .flat(sec_flat));

  // channel source selectors, page 1 control area slots 1 and 2
  for (genvar c = 0; c < SRC_CH; c++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) mdio_src[c*SRC_W +: SRC_W] <= '0;
      else if (wr && page && ctl_area && idx == IDX_W'(c + 1) && !lock[1])
        mdio_src[c*SRC_W +: SRC_W] <= bus_wdata[SRC_W-1:0];
    end
  end

  // registered read port
  logic [31:0] rd_mux;
  pri_word_t   prd;
  assign prd = pri_word_t'(pri_rd);
  always_comb begin
    rd_mux = '0;
    if (pin_ok) begin
      if (!page) rd_mux = {20'b0, prd.drive, prd.pull, 4'b0, prd.func};
      else       rd_mux = 32'(sec_rd);
    end else if (ctl_area) begin
      if (idx == '0)
        rd_mux = {PHYS_BASE[31:1] + LOCK_OFS[31:1] + (page ? PAGE_SPAN[31:1] : 31'b0), lock[page]};
      else if (page && idx == IDX_W'(1)) rd_mux = 32'(mdio_src[SRC_W-1:0]);
      else if (page && idx == IDX_W'(2)) rd_mux = 32'(mdio_src[2*SRC_W-1:SRC_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  pmx_resolve #(.NUM_PINS(NUM_PINS)) u_res (
    .clk(clk), .rst(rst), .pri_flat(pri_flat), .sec_flat(sec_flat),
    .func_o(pin_func), .pull_o(pin_pull), .drive_o(pin_drive));

  // R4: locked pages keep their contents
  assert_locked_pri_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && !page && !ctl_area && lock[0]) |=> $stable(pri_flat));
  assert_locked_sec_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && page && lock[1]) |=> ($stable(sec_flat) && $stable(mdio_src)));
  // R9: a page-0 lock write never touches the page-1 lock
  assert_lock_indep_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && !page && ctl_area) |=> $stable(lock[1]));
endmodule

// File: tb/pinmux_cfg_bank_test.sv
module pinmux_cfg_bank_test;
  localparam int NP = 170;
  localparam int AW = 12;

  logic          clk = 0;
  logic          rst = 1;
  logic          bus_en = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP*7-1:0] pin_func;
  logic [NP*2-1:0] pin_pull, pin_drive;
  logic [5:0]      mdio_src;

  always #5 clk = ~clk;

  pinmux_cfg_bank uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_func(pin_func),
    .pin_pull(pin_pull), .pin_drive(pin_drive), .mdio_src(mdio_src));

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural model
  int m_f[NP], m_p[NP], m_d[NP], m_s[NP];
  int m_md[2];
  int m_lk[2];
  logic [NP*7-1:0] e_func;
  logic [NP*2-1:0] e_pull, e_drive;
  logic [31:0]     e_rd;
  bit started = 0;

  function automatic logic [31:0] m_read(int a);
    int pg = (a >> 11) & 1;
    int off = a & 32'h7FF;
    int ix;
    if (off < 32'h400) begin
      ix = off >> 2;
      if (ix >= NP) return 0;
      if (pg == 0) return (m_d[ix] << 10) | (m_p[ix] << 8) | m_f[ix];
      return m_s[ix];
    end
    ix = (off - 32'h400) >> 2;
    if (ix == 0) return 32'h4000_0400 + pg * 32'h800 + m_lk[pg];
    if (pg == 1 && (ix == 1 || ix == 2)) return m_md[ix-1];
    return 0;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < NP; i++) begin m_f[i]=0; m_p[i]=0; m_d[i]=0; m_s[i]=0; end
      m_md[0]=0; m_md[1]=0; m_lk[0]=1; m_lk[1]=1;
      e_func='0; e_pull='0; e_drive='0; e_rd='0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        e_func[i*7 +: 7] = 7'((m_f[i] == 15) ? 16 + m_s[i] : m_f[i]);
        e_pull[i*2 +: 2] = 2'(m_p[i]);
        e_drive[i*2 +: 2] = 2'(m_d[i]);
      end
      if (bus_en && !bus_we) e_rd = m_read(int'(bus_addr));
      if (bus_en && bus_we) begin
        int a, pg, off, ix;
        a = int'(bus_addr); pg = (a >> 11) & 1; off = a & 32'h7FF;
        if (off < 32'h400) begin
          ix = off >> 2;
          if (ix < NP && m_lk[pg] == 0) begin
            if (pg == 0) begin
              m_f[ix] = bus_wdata[3:0]; m_p[ix] = bus_wdata[9:8]; m_d[ix] = bus_wdata[11:10];
            end else m_s[ix] = bus_wdata[5:0];
          end
        end else begin
          ix = (off - 32'h400) >> 2;
          if (ix == 0) begin
            if (bus_wdata[31:1] == 31'((32'h4000_0400 + pg * 32'h800) >> 1)) m_lk[pg] = bus_wdata[0];
          end else if (pg == 1 && (ix == 1 || ix == 2) && m_lk[1] == 0)
            m_md[ix-1] = bus_wdata[2:0];
        end
      end
    end
  end

  // R7 R8 R1: lock-step comparison on every cycle
  always @(negedge clk) begin
    if (started && !finished) begin
      total++;
      if (pin_func !== e_func || pin_pull !== e_pull || pin_drive !== e_drive ||
          bus_rdata !== e_rd || mdio_src !== 6'({m_md[1][2:0], m_md[0][2:0]})) begin
        bad++;
        $display("FAIL R7/R8 lockstep: rdata=%h exp=%h mdio=%h exp=%h pinmatch=%0b",
                 bus_rdata, e_rd, mdio_src, {m_md[1][2:0], m_md[0][2:0]},
                 pin_func === e_func && pin_pull === e_pull && pin_drive === e_drive);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = AW'(a);
    @(negedge clk);
    bus_en = 0;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset func", 32'(pin_func[7*3 +: 7]), 0);
    chk("R1 reset mdio", 32'(mdio_src), 0);
    rd_chk(32'h400, 32'h4000_0401, "R1 R3 page0 lock readback");
    rd_chk(32'hC00, 32'h4000_0C01, "R1 R3 page1 lock readback");
    // locked write dropped
    wr(3*4, 32'h0000_0F07);
    rd_chk(3*4, 0, "R4 locked page0 write dropped");
    // bad key
    wr(32'h400, 32'h4000_0402);
    rd_chk(32'h400, 32'h4000_0401, "R2 bad key ignored");
    wr(32'h400, 32'h4000_0C00);
    rd_chk(32'h400, 32'h4000_0401, "R2 other page key ignored");
    // unlock page 0
    wr(32'h400, 32'h4000_0400);
    rd_chk(32'h400, 32'h4000_0400, "R2 R3 page0 unlocked");
    rd_chk(32'hC00, 32'h4000_0C01, "R9 page1 still locked");
    // field layout
    wr(3*4, 32'hFFFF_FFF7);
    rd_chk(3*4, 32'h0000_0F07, "R5 field layout");
    @(negedge clk);
    chk("R8 pull out", 32'(pin_pull[3*2 +: 2]), 3);
    chk("R8 drive out", 32'(pin_drive[3*2 +: 2]), 3);
    chk("R7 direct func", 32'(pin_func[3*7 +: 7]), 7);
    wr(9*4, 32'h0000_050E);
    @(negedge clk);
    chk("R7 code 14 passes", 32'(pin_func[9*7 +: 7]), 14);
    // escalation
    wr(5*4, 32'h0000_000F);
    wr(32'h800 + 5*4, 32'd20);
    rd_chk(32'h800 + 5*4, 0, "R4 locked page1 write dropped");
    chk("R7 escalated with zero", 32'(pin_func[5*7 +: 7]), 16);
    wr(32'hC00, 32'h4000_0C00);
    wr(32'h800 + 5*4, 32'hFFFF_FFE9);
    rd_chk(32'h800 + 5*4, 32'h29, "R6 page1 word bits");
    chk("R7 escalated index", 32'(pin_func[5*7 +: 7]), 57);
    // selectors
    wr(32'hC04, 32'hFF);
    wr(32'hC08, 32'h5);
    rd_chk(32'hC04, 7, "R6 selector0");
    rd_chk(32'hC08, 5, "R6 selector1");
    chk("R8 mdio out", 32'(mdio_src), 32'h2F);
    // last pin and out of range
    wr(169*4, 32'h0000_0102);
    rd_chk(169*4, 32'h102, "R10 last pin");
    wr(170*4, 32'h0000_0F05);
    rd_chk(170*4, 0, "R10 beyond last pin");
    // relock
    wr(32'h400, 32'h4000_0401);
    wr(3*4, 32'h0);
    rd_chk(3*4, 32'h0000_0F07, "R4 relocked keeps value");
    rd_chk(32'hC00, 32'h4000_0C00, "R9 page1 still unlocked");
    wr(32'hC00, 32'h4000_0C01);
    wr(32'hC04, 32'h1);
    rd_chk(32'hC04, 7, "R4 locked selector dropped");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule